// File: doc/BRIEF.md
# Multi-Session Logic Self-Test Sequencer

This block runs a random-pattern logic self-test that is too long for one functional pause. It cuts the test into a fixed number of sessions and runs each one during a separate idle gap, for example between two video frames. Inside the block, a 16-bit pattern generator loads scan chains in an external circuit under test. A 16-bit multiple-input signature register compacts what comes out of those chains. For every session the block holds a starting seed and a golden intermediate signature, both as constant parameter tables. It also keeps track of which session comes next.

A session begins when the surrounding system raises a start request while the functional logic reports idle. The sequencer first loads that session's seed and clears the signature register. It then applies the session's patterns. Each pattern is a shift phase the length of one chain followed by one capture cycle. After the last pattern, one more shift phase clears out the final responses. The sequencer then compares the signature with the golden value and reports the result. A pass moves on to the next session, and the index wraps back to the first session after the last one. A mismatch latches a sticky failure, records the session number and leaves the index where it is, so the same session runs again next time.

The controller states are `ST_IDLE`, `ST_SHIFT`, `ST_CAPTURE`, `ST_UNLOAD` and `ST_COMPARE`. Its transitions are:
- launch: `ST_IDLE`→`ST_SHIFT`.
- chain full: `ST_SHIFT`→`ST_CAPTURE`.
- next pattern: `ST_CAPTURE`→`ST_SHIFT`.
- last pattern: `ST_CAPTURE`→`ST_UNLOAD`.
- drained: `ST_UNLOAD`→`ST_COMPARE`.
- report: `ST_COMPARE`→`ST_IDLE`.

Top module: `lbist_session_seq`

## Requirements
- R1: After reset the following outputs are all low or zero: `busy`, `scan_en`, `capture_en`, `scan_in`, `sess_done`, `sess_pass`, `fail_flag`, `fail_sess`, `all_pass` and `next_sess`.
- R2: A session launches only on a clock edge where `start_req` and `func_idle` are both high. If either one is low, the block stays in `ST_IDLE`, no scan activity occurs and `next_sess` does not change.
- R3: The pattern generator is a 16-bit shift register whose feedback is the XOR of bits 15, 13, 12 and 10, shifted left with the feedback entering bit 0.
  - At launch it is loaded with the seed of session `next_sess`.
  - In every shift cycle of a pattern, `scan_in[c]` equals generator bit c, and the generator then advances once.
- R4: Each of the 32 patterns takes 8 cycles with `scan_en` high and `capture_en` low, followed by 1 cycle with `capture_en` high and `scan_en` low.
  - After the last pattern come 8 unload cycles with `scan_en` high and `scan_in` all zero, then 1 compare cycle with neither enable high.
  - `scan_en` and `capture_en` are never high together.
- R5: The signature register is cleared at launch. In every cycle with `scan_en` high it shifts left with the same feedback taps and XORs `scan_out[c]` into bit c.
- R6: In the cycle after the compare cycle, `sess_done` is high for exactly one cycle. `sess_pass` then shows whether the signature equalled the session's golden value.
- R7: A passing session increments `next_sess`. When the last session (index 3) passes, `next_sess` wraps to 0 and `all_pass` goes high and stays high until reset.
- R8: A failing session sets `fail_flag`, which stays high until reset. It also loads `fail_sess` with the session index and leaves `next_sess` unchanged.
- R9: A start request raised while a session is running has no effect: the scan sequence continues unchanged and only one `sess_done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request to run the next session |
| func_idle | input | 1 | Functional logic is in a pause |
| scan_out | input | CHAINS | Serial outputs of the scan chains |
| scan_en | output | 1 | Shift enable for the chains |
| capture_en | output | 1 | Capture pulse for the circuit under test |
| scan_in | output | CHAINS | Serial inputs of the scan chains |
| busy | output | 1 | Session in progress |
| sess_done | output | 1 | One-cycle end-of-session pulse |
| sess_pass | output | 1 | Result of the session just finished |
| fail_flag | output | 1 | Sticky failure indicator |
| fail_sess | output | IDX_W | Index of the last failing session |
| all_pass | output | 1 | Every session has passed at least once |
| next_sess | output | IDX_W | Index of the session that runs next |

## Verification
The hardest situation to reach from the ports is a signature mismatch, because the golden signatures match a fault-free circuit. The bench provides its own model of a circuit under test, with a switchable stuck-at-one fault in one capture bit. It computes every golden signature from that model at elaboration time and passes the values in as parameters. Switching the fault on for one session produces a real mismatch. Switching it off again shows the same session being retried and then passing, while the sticky failure stays set.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SHIFT   = 3'd1,
        ST_CAPTURE = 3'd2,
        ST_UNLOAD  = 3'd3,
        ST_COMPARE = 3'd4
    } lbist_state_e;

endpackage

// File: rtl/lbist_prpg.sv
module lbist_prpg #(
    parameter int              WIDTH = 16,
    parameter logic [WIDTH-1:0] TAPS = 16'hB400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] seed,
    input  logic             step,
    output logic [WIDTH-1:0] state
);

    logic feedback;
    assign feedback = ^(state & TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= '0;
        end else if (load) begin
            state <= seed;
        end else if (step) begin
            state <= {state[WIDTH-2:0], feedback};
        end
    end

    // R3: a non-zero seed never collapses the generator to the all-zero lock-up state
    p_seed_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && seed != '0) |=> (state != '0));

endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
    parameter int               WIDTH  = 16,
    parameter logic [WIDTH-1:0] TAPS   = 16'hB400,
    parameter int               INPUTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              en,
    input  logic [INPUTS-1:0] din,
    output logic [WIDTH-1:0]  sig
);

    localparam int PAD_W = WIDTH - INPUTS;

    logic feedback;
    assign feedback = ^(sig & TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig <= '0;
        end else if (clear) begin
            sig <= '0;
        end else if (en) begin
            sig <= {sig[WIDTH-2:0], feedback} ^ {{PAD_W{1'b0}}, din};
        end
    end

    // R5: clearing at launch leaves an all-zero signature on the next cycle
    p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sig == '0));

endmodule

// File: rtl/lbist_session_seq.sv
module lbist_session_seq
    import lbist_pkg::*;
#(
    parameter int                LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] TAPS      = 16'hB400,
    parameter int                CHAINS    = 4,
    parameter int                CHAIN_LEN = 8,
    parameter int                PATTERNS  = 32,
    parameter int                SESSIONS  = 4,
    parameter logic [SESSIONS-1:0][LFSR_W-1:0] SEEDS    = {16'hC0DE, 16'h7F35, 16'h1D2B, 16'hACE1},
    parameter logic [SESSIONS-1:0][LFSR_W-1:0] EXP_SIGS = {16'h0000, 16'h0000, 16'h0000, 16'h0000},
    localparam int               IDX_W     = (SESSIONS > 1) ? $clog2(SESSIONS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              func_idle,
    input  logic [CHAINS-1:0] scan_out,
    output logic              scan_en,
    output logic              capture_en,
    output logic [CHAINS-1:0] scan_in,
    output logic              busy,
    output logic              sess_done,
    output logic              sess_pass,
    output logic              fail_flag,
    output logic [IDX_W-1:0]  fail_sess,
    output logic              all_pass,
    output logic [IDX_W-1:0]  next_sess
);

    localparam int               BIT_W    = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
    localparam int               PAT_W    = (PATTERNS > 1) ? $clog2(PATTERNS) : 1;
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(CHAIN_LEN - 1);
    localparam logic [PAT_W-1:0] PAT_LAST = PAT_W'(PATTERNS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SESSIONS - 1);

    lbist_state_e       state_q, state_d;
    logic [BIT_W-1:0]   bit_q;
    logic [PAT_W-1:0]   pat_q;
    logic [LFSR_W-1:0]  prpg_q;
    logic [LFSR_W-1:0]  sig_q;
    logic               launch;
    logic               sig_match;

    assign launch    = (state_q == ST_IDLE) && start_req && func_idle;
    assign sig_match = (sig_q == EXP_SIGS[next_sess]);

    lbist_prpg #(.WIDTH(LFSR_W), .TAPS(TAPS)) prpg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (launch),
        .seed  (SEEDS[next_sess]),
        .step  (state_q == ST_SHIFT),
        .state (prpg_q)
    );

    lbist_misr #(.WIDTH(LFSR_W), .TAPS(TAPS), .INPUTS(CHAINS)) misr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (launch),
        .en    (scan_en),
        .din   (scan_out),
        .sig   (sig_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (launch)             state_d = ST_SHIFT;
            ST_SHIFT:   if (bit_q == BIT_LAST)  state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = (pat_q == PAT_LAST) ? ST_UNLOAD : ST_SHIFT;
            ST_UNLOAD:  if (bit_q == BIT_LAST)  state_d = ST_COMPARE;
            ST_COMPARE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        scan_en    = (state_q == ST_SHIFT) || (state_q == ST_UNLOAD);
        capture_en = (state_q == ST_CAPTURE);
        scan_in    = (state_q == ST_SHIFT) ? prpg_q[CHAINS-1:0] : '0;
        busy       = (state_q != ST_IDLE);
    end

    // counters, session index and result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q     <= '0;
            pat_q     <= '0;
            next_sess <= '0;
            sess_done <= 1'b0;
            sess_pass <= 1'b0;
            fail_flag <= 1'b0;
            fail_sess <= '0;
            all_pass  <= 1'b0;
        end else begin
            sess_done <= 1'b0;
            if (launch) begin
                bit_q <= '0;
                pat_q <= '0;
            end
            if (scan_en) begin
                bit_q <= (bit_q == BIT_LAST) ? '0 : bit_q + BIT_W'(1);
            end
            if (capture_en) begin
                pat_q <= pat_q + PAT_W'(1);
            end
            if (state_q == ST_COMPARE) begin
                sess_done <= 1'b1;
                sess_pass <= sig_match;
                if (sig_match) begin
                    if (next_sess == IDX_LAST) begin
                        next_sess <= '0;
                        all_pass  <= 1'b1;
                    end else begin
                        next_sess <= next_sess + IDX_W'(1);
                    end
                end else begin
                    fail_flag <= 1'b1;
                    fail_sess <= next_sess;
                end
            end
        end
    end

    // R2: a session only begins from a joint start request and idle indication
    p_launch_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_req && func_idle));

    // R4: shifting and capturing never overlap
    p_scan_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(scan_en && capture_en));

    // R6: the completion indication is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sess_done |=> !sess_done);

    // R7: passing the last session wraps the index and raises the overall pass flag
    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sess_done && sess_pass && $past(next_sess) == IDX_LAST)
            |-> (next_sess == '0 && all_pass));

    // R8: a mismatch holds the index and records it as the failing session
    p_index_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sess_done && !sess_pass)
            |-> (next_sess == $past(next_sess) && fail_flag && fail_sess == next_sess));

    // R8: the failure flag is sticky
    p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fail_flag |=> fail_flag);

endmodule

// File: tb/lbist_session_seq_tb.sv
module lbist_session_seq_tb_top;

    function automatic logic [15:0] lfsr_step(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    function automatic logic [15:0] misr_step(input logic [15:0] m, input logic [3:0] d);
        return {m[14:0], m[15] ^ m[13] ^ m[12] ^ m[10]} ^ {12'b0, d};
    endfunction

    // bench model of the circuit under test: response computed at capture
    function automatic logic [3:0][7:0] cut_capture(input logic [3:0][7:0] ch, input logic fault);
        logic [3:0][7:0] n;
        for (int c = 0; c < 4; c++) begin
            n[c] = {ch[c][6:0], ch[c][7]} ^ ch[(c + 1) % 4]
                 ^ {4'b0, ch[(c + 3) % 4][3:0] & ch[c][7:4]};
        end
        if (fault) n[2][3] = 1'b1;
        return n;
    endfunction

    function automatic logic [15:0] golden_sig(input logic [15:0] seed);
        logic [15:0]     l;
        logic [15:0]     m;
        logic [3:0][7:0] ch;
        logic [3:0]      so;
        l  = seed;
        m  = '0;
        ch = '0;
        for (int p = 0; p < 32; p++) begin
            for (int b = 0; b < 8; b++) begin
                for (int c = 0; c < 4; c++) so[c] = ch[c][7];
                m = misr_step(m, so);
                for (int c = 0; c < 4; c++) ch[c] = {ch[c][6:0], l[c]};
                l = lfsr_step(l);
            end
            ch = cut_capture(ch, 1'b0);
        end
        for (int b = 0; b < 8; b++) begin
            for (int c = 0; c < 4; c++) so[c] = ch[c][7];
            m = misr_step(m, so);
            for (int c = 0; c < 4; c++) ch[c] = {ch[c][6:0], 1'b0};
        end
        return m;
    endfunction

    localparam logic [15:0] S0 = 16'hACE1;
    localparam logic [15:0] S1 = 16'h1D2B;
    localparam logic [15:0] S2 = 16'h7F35;
    localparam logic [15:0] S3 = 16'hC0DE;
    localparam logic [3:0][15:0] SEEDS_TB = {S3, S2, S1, S0};
    localparam logic [3:0][15:0] EXP_TB   = {golden_sig(S3), golden_sig(S2),
                                             golden_sig(S1), golden_sig(S0)};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_req = 1'b0;
    logic       func_idle = 1'b0;
    logic       fault = 1'b0;
    logic [3:0] scan_out;
    logic       scan_en, capture_en, busy, sess_done, sess_pass, fail_flag, all_pass;
    logic [3:0] scan_in;
    logic [1:0] fail_sess, next_sess;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    lbist_session_seq #(.SEEDS(SEEDS_TB), .EXP_SIGS(EXP_TB)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .func_idle(func_idle),
        .scan_out(scan_out), .scan_en(scan_en), .capture_en(capture_en),
        .scan_in(scan_in), .busy(busy), .sess_done(sess_done), .sess_pass(sess_pass),
        .fail_flag(fail_flag), .fail_sess(fail_sess), .all_pass(all_pass),
        .next_sess(next_sess)
    );

    // stand-in circuit under test
    logic [3:0][7:0] chains;
    always_comb for (int c = 0; c < 4; c++) scan_out[c] = chains[c][7];
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chains <= '0;
        else if (scan_en) begin
            for (int c = 0; c < 4; c++) chains[c] <= {chains[c][6:0], scan_in[c]};
        end else if (capture_en) chains <= cut_capture(chains, fault);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_session(input logic [15:0] seed, input bit exp_pass, input bit poke);
        logic [15:0] m;
        int bad_si, bad_en, dones;
        m = seed; bad_si = 0; bad_en = 0; dones = 0;
        start_req = 1'b1; func_idle = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        for (int p = 0; p < 32; p++) begin
            for (int b = 0; b < 8; b++) begin
                if (!scan_en || capture_en) bad_en++;
                if (scan_in != m[3:0]) bad_si++;
                if (sess_done) dones++;
                m = lfsr_step(m);
                start_req = poke && (p == 5) && (b == 2);
                @(negedge clk);
            end
            if (scan_en || !capture_en) bad_en++;
            start_req = 1'b0;
            @(negedge clk);
        end
        for (int b = 0; b < 8; b++) begin
            if (!scan_en || capture_en) bad_en++;
            if (scan_in != 4'h0) bad_si++;
            @(negedge clk);
        end
        if (scan_en || capture_en || sess_done) bad_en++;
        check(bad_si == 0, "R3 scan_in sequence", bad_si, 0);
        check(bad_en == 0, "R4 shift/capture timing", bad_en, 0);
        @(negedge clk);
        check(sess_done == 1'b1 && dones == 0, "R6 done pulse", sess_done, 1);
        check(sess_pass == exp_pass, "R6 pass result", sess_pass, exp_pass);
        @(negedge clk);
        check(!sess_done && !busy, "R6 done single cycle", sess_done, 0);
        if (poke) check(!busy && dones == 0, "R9 start while busy ignored", dones, 0);
        func_idle = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int act_cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(!busy && !scan_en && !capture_en && scan_in == 0, "R1 scan idle", busy, 0);
        check(!sess_done && !sess_pass && !fail_flag && !all_pass, "R1 flags", fail_flag, 0);
        check(next_sess == 0 && fail_sess == 0, "R1 indices", next_sess, 0);

        // R2: start without idle, then idle without start
        act_cnt = 0;
        start_req = 1'b1; func_idle = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (busy || scan_en || capture_en) act_cnt++;
        end
        check(act_cnt == 0, "R2 start without idle", act_cnt, 0);
        start_req = 1'b0; func_idle = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (busy || scan_en || capture_en) act_cnt++;
        end
        check(act_cnt == 0 && next_sess == 0, "R2 idle without start", act_cnt, 0);

        // R3-R7, R9: all four sessions on a good circuit
        for (int s = 0; s < 4; s++) begin
            check(all_pass == 1'b0, "R7 all_pass low before last", all_pass, 0);
            run_session(SEEDS_TB[s], 1'b1, s == 1);
            check(next_sess == 2'((s + 1) % 4), "R7 index advance", next_sess, (s + 1) % 4);
            check(!fail_flag, "R8 no failure on good circuit", fail_flag, 0);
        end
        check(all_pass == 1'b1 && next_sess == 0, "R7 wrap and all_pass", all_pass, 1);

        // R8: faulty circuit on session 0
        fault = 1'b1;
        run_session(SEEDS_TB[0], 1'b0, 1'b0);
        check(fail_flag && fail_sess == 0, "R8 failure recorded", fail_sess, 0);
        check(next_sess == 0, "R8 index held", next_sess, 0);
        check(all_pass == 1'b1, "R7 all_pass sticky", all_pass, 1);

        // R8: retry after fault removed
        fault = 1'b0;
        run_session(SEEDS_TB[0], 1'b1, 1'b0);
        check(next_sess == 1 && fail_flag, "R8 retry passes, flag sticky", next_sess, 1);

        // R2: idle low again while index is 1
        start_req = 1'b1; func_idle = 1'b0;
        act_cnt = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (busy || scan_en) act_cnt++;
        end
        start_req = 1'b0;
        check(act_cnt == 0 && next_sess == 1, "R2 gated at index 1", act_cnt, 0);

        // R8: failure on session 1
        fault = 1'b1;
        run_session(SEEDS_TB[1], 1'b0, 1'b0);
        check(fail_sess == 1 && next_sess == 1, "R8 failing session number", fail_sess, 1);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule